// File: doc/BRIEF.md
# Configurable-Timing SPI Master Shift Engine

This block is the serial engine of an SPI master. A host hands it one byte at a time on a transmit stream; as soon as a byte is accepted the engine runs an 8-bit transfer on its own serial clock. It shifts the byte out most significant bit first on `sdo` and shifts the byte on `sdi` in at the same time. When the eighth bit has been captured, the received byte is posted on a receive stream and an interrupt flag is raised. Only the engine drives the serial clock, so nothing on the serial side has to give permission for a transfer to begin.

Four plain configuration inputs set the timing. `rate_sel` picks the bit rate: the system clock divided by 4, 16 or 64, or half the rate of an external timer tick. `cpol` sets the idle level of `sck`. `cke` sets whether `sdo` is already valid before the first `sck` edge or changes on that edge. `smp` sets whether `sdi` is captured in the middle or at the end of each bit. A receive-only input releases the `sdo` driver. In that mode the engine starts transfers back to back with no host write, so it keeps capturing the line and posting every byte.

The transmit stream does not apply back-pressure to a waiting beat. `tx_ready` is low while a transfer runs. A beat offered with `tx_valid` while `tx_ready` is low is discarded, not held, and it sets a collision flag. On the receive stream, `rx_valid` holds with stable `rx_data` until the host completes a handshake with `rx_ready`. A byte that completes while an unread byte is still held is dropped, and the overflow flag is set.

Top module: `spi_shift_master`

## Requirements
- R1: In the cycle after `tx_valid && tx_ready`, a transfer runs and `tx_ready` is low until it ends. `sdo` presents the accepted byte bit 7 first, one bit per bit time.
- R2: With `rate_sel` 0, 1 or 2, one bit time is 4, 16 or 64 system clocks. Half a bit time is H = 2, 8 or 32 clocks. Half-bit k of a transfer (k = 0..15) spans clocks k*H to k*H+H-1 after the accepting edge.
- R3: With `rate_sel` = 3, each `timer_tick` pulse ends one half-bit, so a transfer needs exactly 16 ticks. Without ticks the engine does not advance.
- R4: `sck` equals `cpol` whenever no transfer runs. During half-bit k, `sck` equals `cpol` XOR (k odd when `cke`=1, k even when `cke`=0).
- R5: With `cke`=1, `sdo` carries bit 7 from the accepting edge and `sck` stays idle through half-bit 0. With `cke`=0, `sck` leaves its idle level at the accepting edge, the same edge on which `sdo` takes bit 7.
- R6: With `smp`=0, `sdi` is captured at the end of the first half of each bit. With `smp`=1, it is captured at the end of the second half.
- R7: At the edge ending half-bit 15, the byte (first captured bit in bit 7) appears on `rx_data`, and `rx_valid` and `irq` go high.
- R8: `rx_valid` and `rx_data` hold until `rx_valid && rx_ready`. That handshake clears `rx_valid` on the next edge.
- R9: If a byte completes while `rx_valid` is high and no handshake occurs in that cycle, `ovf` is set and `rx_data` keeps the older byte. `ovf_clr` clears `ovf`.
- R10: `tx_valid` while `tx_ready` is low is ignored and sets `wcol`. The running byte is unchanged. `wcol_clr` clears `wcol`.
- R11: `irq` stays set until an `irq_clr` pulse. A completion in the same cycle keeps it set.
- R12: With `rx_only`=1, `sdo_oe` is low and a new transfer starts whenever the engine is idle, with no host write. Each such byte is posted as in R7 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 2 | Bit rate: 0 = /4, 1 = /16, 2 = /64, 3 = timer tick / 2 |
| cpol | input | 1 | Idle level of sck |
| cke | input | 1 | 1 = sdo valid before first sck edge, 0 = sdo changes on it |
| smp | input | 1 | 0 = capture sdi mid-bit, 1 = at end of bit |
| rx_only | input | 1 | Release sdo and run transfers continuously |
| timer_tick | input | 1 | External timer pulse used when rate_sel = 3 |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Engine idle, a byte would be accepted |
| rx_valid | output | 1 | Received byte held |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Host takes the received byte |
| irq_clr | input | 1 | Clears irq |
| wcol_clr | input | 1 | Clears wcol |
| ovf_clr | input | 1 | Clears ovf |
| irq | output | 1 | Transfer-complete flag |
| wcol | output | 1 | Write-collision flag |
| ovf | output | 1 | Receive-overflow flag |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the sdo pad |
| sdi | input | 1 | Serial data in |

## Verification
The assertions check the cycle-level rules on every cycle: `sck` rests at `cpol` whenever the engine is idle, an accepted byte drops `tx_ready`, an offered beat while busy raises `wcol`, a held byte stays valid and stable until its handshake, a posted byte raises `irq`, and in timer mode `sck` stands still without a tick. Only the bench scenarios show the rest. These are the bit order and the exact half-bit schedule at each rate, where `sdo` launches and where `sdi` is sampled for each `cke`/`smp` pair (data that changes mid-bit tells mid from end), the 16-tick count in timer mode, that the running byte survives a collision, and that receive-only mode keeps posting bytes until one is dropped as an overflow.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  typedef enum logic [1:0] {
    RATE_FAST  = 2'd0,
    RATE_MID   = 2'd1,
    RATE_SLOW  = 2'd2,
    RATE_TIMER = 2'd3
  } rate_e;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick
  import spi_shift_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  rate_e rate,
  input  logic  timer_tick,
  output logic  half_tick
);
  localparam int HALF_FAST = DIV_FAST / 2;
  localparam int HALF_MID  = DIV_MID / 2;
  localparam int HALF_SLOW = DIV_SLOW / 2;
  localparam int CW        = $clog2(HALF_SLOW + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    case (rate)
      RATE_FAST: lim = CW'(HALF_FAST - 1);
      RATE_MID:  lim = CW'(HALF_MID - 1);
      RATE_SLOW: lim = CW'(HALF_SLOW - 1);
      default:   lim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (!run || rate == RATE_TIMER) cnt <= '0;
    else if (cnt >= lim)                 cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end

  assign half_tick = run && ((rate == RATE_TIMER) ? timer_tick : (cnt >= lim));
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx_byte,
  input  logic         half_tick,
  input  logic         cpol,
  input  logic         cke,
  input  logic         smp,
  input  logic         sdi,
  output logic         busy,
  output logic         sck,
  output logic         sdo,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  localparam int HALVES = 2 * W;
  localparam int PW     = $clog2(HALVES);

  logic [PW-1:0] ph;
  logic [W-1:0]  tx_sr;
  logic [W-1:0]  rx_sr;
  logic          act_q;
  logic          last;

  assign last = (ph == PW'(HALVES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ph    <= '0;
      tx_sr <= '0;
      rx_sr <= '0;
      act_q <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        ph    <= '0;
        tx_sr <= tx_byte;
        act_q <= ~cke;
      end
    end else if (half_tick) begin
      // even half ends mid-bit, odd half ends the bit
      if (ph[0] == smp) rx_sr <= {rx_sr[W-2:0], sdi};
      if (last) begin
        busy  <= 1'b0;
        act_q <= 1'b0;
      end else begin
        ph    <= ph + 1'b1;
        act_q <= ~act_q;
        if (ph[0]) tx_sr <= {tx_sr[W-2:0], 1'b0};
      end
    end
  end

  assign sck     = cpol ^ act_q;
  assign sdo     = tx_sr[W-1];
  assign done    = busy && half_tick && last;
  assign rx_byte = smp ? {rx_sr[W-2:0], sdi} : rx_sr;
endmodule

// File: rtl/spi_rx_post.sv
module spi_rx_post #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done,
  input  logic [W-1:0] rx_byte,
  input  logic         rx_ready,
  input  logic         irq_clr,
  input  logic         ovf_clr,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         irq,
  output logic         ovf
);
  logic taken;
  assign taken = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      irq      <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      if (done) begin
        if (rx_valid && !taken) begin
          ovf <= 1'b1;
        end else begin
          rx_data  <= rx_byte;
          rx_valid <= 1'b1;
        end
      end else if (taken) begin
        rx_valid <= 1'b0;
      end
      if (done && !(rx_valid && !taken)) begin
        // ovf already handled above
      end else if (ovf_clr && !(done && rx_valid && !taken)) begin
        ovf <= 1'b0;
      end
      if (done)         irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_shift_pkg::*;
#(
  parameter int W        = 8,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   rate_sel,
  input  logic         cpol,
  input  logic         cke,
  input  logic         smp,
  input  logic         rx_only,
  input  logic         timer_tick,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ready,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  input  logic         rx_ready,
  input  logic         irq_clr,
  input  logic         wcol_clr,
  input  logic         ovf_clr,
  output logic         irq,
  output logic         wcol,
  output logic         ovf,
  output logic         sck,
  output logic         sdo,
  output logic         sdo_oe,
  input  logic         sdi
);
  logic         busy;
  logic         half_tick;
  logic         start;
  logic         done;
  logic [W-1:0] start_byte;
  logic [W-1:0] rx_byte;
  rate_e        rate;

  assign rate       = rate_e'(rate_sel);
  assign tx_ready   = ~busy;
  assign start      = (tx_valid || rx_only) && !busy;
  assign start_byte = tx_valid ? tx_data : '0;
  assign sdo_oe     = ~rx_only;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    wcol <= 1'b0;
    else if (tx_valid && busy)     wcol <= 1'b1;
    else if (wcol_clr)             wcol <= 1'b0;
  end

  spi_half_tick #(
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .rate(rate),
    .timer_tick(timer_tick), .half_tick(half_tick)
  );

  spi_bit_engine #(.W(W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(start_byte),
    .half_tick(half_tick), .cpol(cpol), .cke(cke), .smp(smp), .sdi(sdi),
    .busy(busy), .sck(sck), .sdo(sdo), .done(done), .rx_byte(rx_byte)
  );

  spi_rx_post #(.W(W)) u_post (
    .clk(clk), .rst_n(rst_n), .done(done), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
    .rx_valid(rx_valid), .rx_data(rx_data), .irq(irq), .ovf(ovf)
  );
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   rate_sel,
  input logic         cpol,
  input logic         timer_tick,
  input logic         tx_valid,
  input logic         tx_ready,
  input logic         rx_valid,
  input logic [W-1:0] rx_data,
  input logic         rx_ready,
  input logic         irq,
  input logic         wcol,
  input logic         sck
);
  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (sck == cpol));

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R10
  collision_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> wcol);

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R7
  post_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> irq);

  // R3
  tick_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 2'd3 && !timer_tick && !tx_ready) |=> ($stable(sck) || !$stable(cpol)));
endmodule

bind spi_shift_master spi_shift_master_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .cpol(cpol),
  .timer_tick(timer_tick), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
  .irq(irq), .wcol(wcol), .sck(sck)
);

// File: tb/spi_shift_master_bench.sv
module spi_shift_master_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       cpol = 1'b0, cke = 1'b1, smp = 1'b0, rx_only = 1'b0;
  logic       timer_tick = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, rx_valid;
  logic [7:0] rx_data;
  logic       rx_ready = 1'b0, irq_clr = 1'b0, wcol_clr = 1'b0, ovf_clr = 1'b0;
  logic       irq, wcol, ovf, sck, sdo, sdo_oe;
  logic       sdi = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_shift_master u_spi_shift_master (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .cpol(cpol), .cke(cke),
    .smp(smp), .rx_only(rx_only), .timer_tick(timer_tick),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .irq_clr(irq_clr), .wcol_clr(wcol_clr), .ovf_clr(ovf_clr),
    .irq(irq), .wcol(wcol), .ovf(ovf), .sck(sck), .sdo(sdo),
    .sdo_oe(sdo_oe), .sdi(sdi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_rx();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_ready && !rx_valid && !irq && !wcol && !ovf, "R1 reset idle",
          {tx_ready, rx_valid, irq, wcol, ovf}, 5'b10000);
    check(sck == 1'b0 && sdo_oe, "R4 reset sck/oe", {sck, sdo_oe}, 2'b01);
  endtask

  // cycle-exact transfer; sdi carries a[] in the first half of each bit, b[] in the second
  task automatic t_xfer(input logic [1:0] rs, input logic p, input logic k, input logic s,
                        input logic [7:0] tx, input logic [7:0] a, input logic [7:0] b);
    int h_len = (rs == 2'd0) ? 2 : (rs == 2'd1) ? 8 : 32;
    int sck_err = 0;
    logic [7:0] got = 8'h00;
    logic [7:0] exp_rx = s ? b : a;
    rate_sel = rs; cpol = p; cke = k; smp = s; sdi = a[7];
    @(negedge clk);
    check(sck == p, "R4 idle level", sck, p);
    tx_valid = 1'b1; tx_data = tx;
    for (int c = 0; c <= 16 * h_len; c++) begin
      @(negedge clk);
      tx_valid = 1'b0;
      if (c < 16 * h_len) begin
        int h = c / h_len;
        int bi = h / 2;
        logic act = k ? h[0] : ~h[0];
        if (sck !== (p ^ act)) sck_err++;
        if (c == 0) begin
          // R5 launch point
          check(sdo == tx[7], "R5 sdo bit7 at accept", sdo, tx[7]);
          check(sck == (k ? p : ~p), "R5 first edge placement", sck, k ? p : ~p);
          check(!tx_ready, "R1 busy after accept", tx_ready, 0);
        end
        if ((c % h_len) == 0 && h[0]) got[7 - bi] = sdo;
        sdi = h[0] ? b[7 - bi] : a[7 - bi];
      end else begin
        check(rx_valid && irq, "R7 posted at end of half 15", {rx_valid, irq}, 2'b11);
        check(rx_data == exp_rx, "R6 sample point", rx_data, exp_rx);
        check(tx_ready && sck == p, "R4 idle after transfer", {tx_ready, sck}, {1'b1, p});
      end
    end
    check(sck_err == 0, "R2 half-bit schedule", sck_err, 0);
    check(got == tx, "R1 msb-first sdo", got, tx);
    read_rx();
    check(!rx_valid, "R8 handshake clears", rx_valid, 0);
    check(irq, "R11 irq held until clear", irq, 1);
    clear_irq();
    check(!irq, "R11 irq cleared", irq, 0);
  endtask

  task automatic t_timer();
    int ticks = 0;
    rate_sel = 2'd3; cpol = 1'b0; cke = 1'b1; smp = 1'b0; sdi = 1'b1;
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'hA5;
    @(negedge clk); tx_valid = 1'b0;
    repeat (40) @(negedge clk);
    check(!tx_ready && sck == 1'b0, "R3 stall without tick", {tx_ready, sck}, 2'b00);
    while (!rx_valid && ticks < 40) begin
      timer_tick = 1'b1; ticks++;
      @(negedge clk); timer_tick = 1'b0;
      @(negedge clk);
    end
    check(ticks == 16, "R3 sixteen ticks per byte", ticks, 16);
    check(rx_data == 8'hFF, "R3 timer-rate data", rx_data, 8'hFF);
    read_rx(); clear_irq();
  endtask

  task automatic t_collision();
    int guard = 0;
    rate_sel = 2'd0; cpol = 1'b0; cke = 1'b1; smp = 1'b0;
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'h3C; sdi = 1'b0;
    @(negedge clk); tx_valid = 1'b0; sdi = sdo;
    repeat (4) begin @(negedge clk); sdi = sdo; end
    tx_valid = 1'b1; tx_data = 8'hFF;
    @(negedge clk); tx_valid = 1'b0; sdi = sdo;
    check(wcol, "R10 collision flag", wcol, 1);
    while (!rx_valid && guard < 200) begin @(negedge clk); sdi = sdo; guard++; end
    check(rx_data == 8'h3C, "R10 running byte kept", rx_data, 8'h3C);
    @(negedge clk); wcol_clr = 1'b1;
    @(negedge clk); wcol_clr = 1'b0;
    check(!wcol, "R10 collision cleared", wcol, 0);
    read_rx(); clear_irq();
  endtask

  task automatic t_rxonly();
    int guard = 0;
    rate_sel = 2'd0; cpol = 1'b1; cke = 1'b0; smp = 1'b1; sdi = 1'b1;
    @(negedge clk); rx_only = 1'b1;
    @(negedge clk);
    check(!sdo_oe, "R12 sdo released", sdo_oe, 0);
    while (!rx_valid && guard < 200) begin @(negedge clk); guard++; end
    check(rx_valid && rx_data == 8'hFF, "R12 byte without host write", rx_data, 8'hFF);
    sdi = 1'b0; guard = 0;
    while (!ovf && guard < 200) begin @(negedge clk); guard++; end
    check(ovf, "R9 overflow set", ovf, 1);
    check(rx_data == 8'hFF, "R9 old byte kept", rx_data, 8'hFF);
    rx_only = 1'b0; guard = 0;
    while (!tx_ready && guard < 200) begin @(negedge clk); guard++; end
    @(negedge clk);
    check(tx_ready, "R12 stops when released", tx_ready, 1);
    read_rx();
    check(!rx_valid, "R8 read after overflow", rx_valid, 0);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check(!ovf, "R9 overflow cleared", ovf, 0);
    clear_irq();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_xfer(2'd0, 1'b0, 1'b1, 1'b0, 8'hA5, 8'h5A, 8'h5A);
    t_xfer(2'd1, 1'b1, 1'b0, 1'b0, 8'h81, 8'hC3, 8'h3C);
    t_xfer(2'd2, 1'b0, 1'b0, 1'b1, 8'h6E, 8'hC3, 8'h3C);
    t_xfer(2'd0, 1'b1, 1'b1, 1'b1, 8'h17, 8'h0F, 8'hF0);
    t_timer();
    t_collision();
    t_rxonly();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule